// File: doc/BRIEF.md
# Bidirectional Latched Bus Transceiver

This block passes byte-wide data between two ports, A and B, without inverting it. Each direction has its own storage bank. One bank takes data from A and presents it on B. The other takes data from B and presents it on A. Each direction is steered by three active-low controls: a chip enable, a latch enable and an output enable. The chip enable gates both loading the bank and driving the far port. The latch enable chooses between following the input and holding it. The output enable decides whether the far port is driven.

Each bidirectional port is split into an input bus, an output bus and a drive-enable bit. A wrapper at pad level can join the three into one tristate pin. The latches are modelled in a clocked domain. While a bank is open, its output follows its input port combinationally, and the bank also reloads from that input on every clock edge. When the latch enable rises, the bank keeps the value it took at the last edge on which it was open.

Each direction has a lane state machine with three states:
- `LANE_OFF`: the chip enable is high.
- `LANE_OPEN`: the chip enable and the latch enable are both low.
- `LANE_HELD`: the chip enable is low and the latch enable is high.

On every clock edge a lane moves to the state its controls select, whatever state it is in. The possible moves are OFF→OPEN, OFF→HELD, OPEN→HELD, HELD→OPEN, and any state→OFF. An active-low asynchronous reset clears both banks and sets both lanes to `LANE_OFF`.

Top module: `xcvr_latch_top`

## Requirements
- R1: While reset is asserted, and after it is released, both banks read zero until they are loaded.
- R2: The A-to-B bank and the B-to-A bank operate independently. One direction's controls and data never change the other direction's output.
- R3: While a direction's chip enable is high, its bank keeps its value. Its drive-enable is 0, whatever its latch enable and output enable are.
- R4: With chip enable low and latch enable low, the bank is transparent. Its output bus equals its input port in the same cycle.
- R5: When the latch enable goes from low to high with chip enable low, the bank holds the input value present at the last clock edge where it was open. Later input changes do not reach the output.
- R6: With chip enable low and latch enable high, the bank keeps its stored value.
- R7: A port's drive-enable is 1 only when that direction's chip enable and output enable are both low. b_oe belongs to A-to-B and a_oe belongs to B-to-A.
- R8: The output bus always carries the bank contents without inversion, or the live input while the bank is transparent. This holds whether or not the port is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at which the banks sample |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_in | input | W | Data arriving at port A |
| a_out | output | W | Data presented toward port A (B-to-A bank) |
| a_oe | output | 1 | Port A drive-enable |
| b_in | input | W | Data arriving at port B |
| b_out | output | W | Data presented toward port B (A-to-B bank) |
| b_oe | output | 1 | Port B drive-enable |
| ab_ce_n | input | 1 | A-to-B chip enable, active low |
| ab_le_n | input | 1 | A-to-B latch enable, active low |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ba_ce_n | input | 1 | B-to-A chip enable, active low |
| ba_le_n | input | 1 | B-to-A latch enable, active low |
| ba_oe_n | input | 1 | B-to-A output enable, active low |

## Verification
The assertions check the following on every cycle for both directions:
- output follows input while a bank is transparent;
- a closing bank captures its last input;
- output stays stable while the latch enable stays high or the chip enable stays off;
- drive-enable agrees with chip enable and output enable.

Some behaviours only the bench scenarios can show. These are that the two banks stay isolated under interleaved traffic, and that a bank disabled by chip enable ignores a low latch enable. The bench also checks the reset contents and the exact byte a bank holds after a long run of mixed control patterns.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
    typedef enum logic [1:0] {
        LANE_OFF  = 2'd0,
        LANE_OPEN = 2'd1,
        LANE_HELD = 2'd2
    } lane_state_e;

    localparam int unsigned NUM_DIR = 2;
endpackage

// File: rtl/xcvr_lane_fsm.sv
module xcvr_lane_fsm
    import xcvr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ce_n,
    input  logic        le_n,
    input  logic        oe_n,
    output lane_state_e state,
    output logic        open,
    output logic        drive
);
    lane_state_e nxt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= LANE_OFF;
        else        state <= nxt;
    end

    // next-state selection from the live controls
    always_comb begin
        nxt = state;
        unique case (state)
            LANE_OFF, LANE_OPEN, LANE_HELD: begin
                if (ce_n)       nxt = LANE_OFF;
                else if (!le_n) nxt = LANE_OPEN;
                else            nxt = LANE_HELD;
            end
            default: nxt = LANE_OFF;
        endcase
    end

    // outputs: bank open now, far port driven now
    always_comb begin
        open  = !ce_n && !le_n;
        drive = !ce_n && !oe_n;
    end
endmodule

// File: rtl/xcvr_bank.sv
module xcvr_bank #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         open,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] mem_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    mem_q <= '0;
        else if (open) mem_q <= din;
    end

    assign dout = open ? din : mem_q;
endmodule

// File: rtl/xcvr_latch_top.sv
module xcvr_latch_top
    import xcvr_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] b_out,
    output logic         b_oe,
    input  logic         ab_ce_n,
    input  logic         ab_le_n,
    input  logic         ab_oe_n,
    input  logic         ba_ce_n,
    input  logic         ba_le_n,
    input  logic         ba_oe_n
);
    // index 0: A-to-B, index 1: B-to-A
    logic [NUM_DIR-1:0]        ce_n_v, le_n_v, oe_n_v, open_v, drive_v;
    logic [NUM_DIR-1:0][W-1:0] din_v, dout_v;
    lane_state_e               ab_st, ba_st;
    lane_state_e               st_v [NUM_DIR];

    assign ce_n_v = {ba_ce_n, ab_ce_n};
    assign le_n_v = {ba_le_n, ab_le_n};
    assign oe_n_v = {ba_oe_n, ab_oe_n};
    assign din_v  = {b_in, a_in};

    for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
        xcvr_lane_fsm u_fsm (
            .clk   (clk),
            .rst_n (rst_n),
            .ce_n  (ce_n_v[d]),
            .le_n  (le_n_v[d]),
            .oe_n  (oe_n_v[d]),
            .state (st_v[d]),
            .open  (open_v[d]),
            .drive (drive_v[d])
        );
        xcvr_bank #(.W(W)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .open  (open_v[d]),
            .din   (din_v[d]),
            .dout  (dout_v[d])
        );
    end

    assign ab_st = st_v[0];
    assign ba_st = st_v[1];
    assign b_out = dout_v[0];
    assign b_oe  = drive_v[0];
    assign a_out = dout_v[1];
    assign a_oe  = drive_v[1];
endmodule

// File: rtl/xcvr_checker.sv
module xcvr_checker
    import xcvr_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] a_in,
    input logic [W-1:0] a_out,
    input logic         a_oe,
    input logic [W-1:0] b_in,
    input logic [W-1:0] b_out,
    input logic         b_oe,
    input logic         ab_ce_n,
    input logic         ab_le_n,
    input logic         ab_oe_n,
    input logic         ba_ce_n,
    input logic         ba_le_n,
    input logic         ba_oe_n,
    input lane_state_e  ab_st,
    input lane_state_e  ba_st
);
    always_comb begin
        if (!rst_n) begin
            p_reset_clear_r1: assert (ab_st == LANE_OFF && ba_st == LANE_OFF);
        end
    end

    p_off_hold_ab_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ab_st == LANE_OFF && ab_ce_n) |-> $stable(b_out) && !b_oe);
    p_off_hold_ba_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ba_st == LANE_OFF && ba_ce_n) |-> $stable(a_out) && !a_oe);

    p_follow_ab_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ab_ce_n && !ab_le_n) |-> b_out == a_in);
    p_follow_ba_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ba_ce_n && !ba_le_n) |-> a_out == b_in);

    p_capture_ab_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ab_st == LANE_OPEN && ab_le_n) |-> b_out == $past(a_in));
    p_capture_ba_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ba_st == LANE_OPEN && ba_le_n) |-> a_out == $past(b_in));

    p_held_ab_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ab_st == LANE_HELD && ab_le_n) |-> $stable(b_out));
    p_held_ba_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ba_st == LANE_HELD && ba_le_n) |-> $stable(a_out));

    p_drive_ab_r7: assert property (@(posedge clk) disable iff (!rst_n)
        b_oe |-> (!ab_ce_n && !ab_oe_n));
    p_drive_ba_r7: assert property (@(posedge clk) disable iff (!rst_n)
        a_oe |-> (!ba_ce_n && !ba_oe_n));
endmodule

bind xcvr_latch_top xcvr_checker #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .a_in    (a_in),
    .a_out   (a_out),
    .a_oe    (a_oe),
    .b_in    (b_in),
    .b_out   (b_out),
    .b_oe    (b_oe),
    .ab_ce_n (ab_ce_n),
    .ab_le_n (ab_le_n),
    .ab_oe_n (ab_oe_n),
    .ba_ce_n (ba_ce_n),
    .ba_le_n (ba_le_n),
    .ba_oe_n (ba_oe_n),
    .ab_st   (ab_st),
    .ba_st   (ba_st)
);

// File: tb/test_xcvr_latch_top.sv
module test_xcvr_latch_top;
    localparam int W = 8;

    typedef struct {
        logic [W-1:0] a_out;
        logic         a_oe;
        logic [W-1:0] b_out;
        logic         b_oe;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic [W-1:0] a_out, b_out;
    logic         a_oe, b_oe;
    logic         ab_ce_n = 1'b1, ab_le_n = 1'b1, ab_oe_n = 1'b1;
    logic         ba_ce_n = 1'b1, ba_le_n = 1'b1, ba_oe_n = 1'b1;

    int           n_vec = 0;
    int           n_bad = 0;
    exp_t         sb_q[$];
    logic [W-1:0] m_ab = '0, m_ba = '0;
    bit           done = 1'b0;

    always #4 clk = ~clk;

    xcvr_latch_top #(.W(W)) i_xcvr_latch_top (
        .clk(clk), .rst_n(rst_n),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
        .ab_ce_n(ab_ce_n), .ab_le_n(ab_le_n), .ab_oe_n(ab_oe_n),
        .ba_ce_n(ba_ce_n), .ba_le_n(ba_le_n), .ba_oe_n(ba_oe_n)
    );

    // driver: one vector per cycle, expectation pushed into the scoreboard
    task automatic apply(input logic [W-1:0] ai, input logic [W-1:0] bi,
                         input logic [2:0] abc, input logic [2:0] bac,
                         input string tag);
        exp_t e;
        logic ab_open, ba_open;
        @(negedge clk);
        a_in = ai; b_in = bi;
        {ab_ce_n, ab_le_n, ab_oe_n} = abc;
        {ba_ce_n, ba_le_n, ba_oe_n} = bac;
        ab_open = !abc[2] && !abc[1];
        ba_open = !bac[2] && !bac[1];
        e.b_out = ab_open ? ai : m_ab;
        e.b_oe  = !abc[2] && !abc[0];
        e.a_out = ba_open ? bi : m_ba;
        e.a_oe  = !bac[2] && !bac[0];
        e.tag   = tag;
        sb_q.push_back(e);
        // model the bank update at the coming rising edge
        if (ab_open) m_ab = ai;
        if (ba_open) m_ba = bi;
    endtask

    // monitor: sample late in the cycle, well away from the rising edge
    initial begin
        forever begin
            @(negedge clk);
            #3;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                n_vec++;
                if (a_out !== e.a_out || a_oe !== e.a_oe ||
                    b_out !== e.b_out || b_oe !== e.b_oe) begin
                    n_bad++;
                    $display("FAIL %s: got a=%h/%b b=%h/%b, expected a=%h/%b b=%h/%b",
                             e.tag, a_out, a_oe, b_out, b_oe,
                             e.a_out, e.a_oe, e.b_out, e.b_oe);
                end
            end
        end
    end

    // watchdog
    initial begin
        #(200000 * 8);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got hang, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: bank contents during reset, controls idle
        #6;
        n_vec++;
        if (a_out !== '0 || b_out !== '0 || a_oe !== 1'b0 || b_oe !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: got a=%h b=%h, expected 00 00", a_out, b_out);
        end
        @(negedge clk); rst_n = 1'b1;
        // controls as {ce_n, le_n, oe_n}
        apply(8'hAA, 8'h55, 3'b111, 3'b111, "R1");           // off, reads zero
        apply(8'h5A, 8'h00, 3'b000, 3'b111, "R4");           // AB transparent, driven
        apply(8'hC3, 8'h00, 3'b000, 3'b111, "R4");           // follows live
        apply(8'h11, 8'h00, 3'b010, 3'b111, "R5");           // close: keep C3
        apply(8'h22, 8'h00, 3'b010, 3'b111, "R6");           // still C3
        apply(8'h22, 8'h00, 3'b011, 3'b111, "R7");           // oe high: not driven
        apply(8'h77, 8'h00, 3'b100, 3'b111, "R3");           // ce high ignores le, oe
        apply(8'h78, 8'h00, 3'b100, 3'b111, "R3");           // still C3, not driven
        apply(8'h00, 8'h96, 3'b010, 3'b000, "R2");           // BA open, AB held
        apply(8'h00, 8'h69, 3'b010, 3'b010, "R5");           // BA closes on 96
        apply(8'h0F, 8'hF0, 3'b001, 3'b011, "R8");           // AB transparent, undriven
        apply(8'hFF, 8'h01, 3'b110, 3'b010, "R7");           // ce high: B undriven
        apply(8'h80, 8'h01, 3'b000, 3'b000, "R8");           // both directions drive
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r;
            r = $urandom;
            apply(r[7:0], r[15:8], r[18:16], r[21:19], "R2");
        end
        apply(8'h00, 8'h00, 3'b111, 3'b111, "R6");
        @(negedge clk); @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule